// File: doc/BRIEF.md
# Fault-Address Register Access Decoder

This block decides what happens to a system-register access aimed at one of two fault-address registers. One register belongs to the kernel privilege level and the other to the hypervisor level. Each request carries the following:

- the current privilege level, from 0 to 3;
- the five-field register selector;
- a read/write flag and write data;
- the state of the hypervisor configuration: enable, three nesting bits, a host-mode bit, the virtual-memory trap bits, the fine-grained trap bits with their enable, and whether the top privilege level exists.

The block resolves every request to exactly one of five outcomes:

- undefined;
- a trap to the hypervisor;
- a redirect into a memory slot;
- the kernel register;
- the hypervisor register.

The two registers and the memory slot are held in simple storage inside the block. Writes that resolve to a storage outcome update that storage. Reads return its contents.

The response is registered and appears one cycle after the request. It carries the outcome code, a trap syndrome, a slot offset and read data. A core's system-instruction pipeline uses it to steer an access, or to raise the exception, without decoding the aliasing rules itself.

Top module: `sysreg_access_dec`

## Requirements
- R1: The hypervisor register is selected by op0=2'b11, op1=3'b100, CRn=4'b0110, CRm=4'b0000, op2=3'b000. The kernel register uses the same code with op1=3'b000. Any other selector gives outcome 0 (undefined) and changes no storage.
- R2: Any request at level 0 gives outcome 0, whichever encoding it uses.
- R3: At level 1, the hypervisor encoding is decided in this order:
  - enable, nest_mem and nest_base all set gives outcome 3 (kernel register);
  - otherwise enable with nest_base gives outcome 1 (trap);
  - otherwise it gives outcome 0.
- R4: At level 1 with the hypervisor enabled, the kernel encoding gives outcome 1 when the virtual-memory trap bit for its direction is set. A read uses vm_trap_rd and a write uses vm_trap_wr. This check ranks above every other level-1 kernel rule.
- R5: At level 1 with the hypervisor enabled and no virtual-memory trap, the kernel encoding gives outcome 1 when the fine-grained trap bit for its direction is set. That bit counts only if fg_enable is 1 or top_level_present is 0.
- R6: At level 1 with the hypervisor enabled and no trap, all three nest bits set give outcome 2 (memory redirect). The response then carries rsp_addr = 0x220, and the access reads or writes the slot storage.
- R7: At level 1, a kernel-encoding access that meets none of the above gives outcome 3. With the enable low, every trap and nest bit is ignored.
- R8: At level 2, the kernel encoding gives outcome 4 (hypervisor register) when host_mode is 1, and outcome 3 otherwise. The hypervisor encoding always gives outcome 4.
- R9: At level 3, each encoding gives its own register: kernel gives outcome 3 and hypervisor gives outcome 4.
- R10: rsp_valid is high exactly one cycle after each req_valid cycle. rsp_syndrome is 0x18 on outcome 1 and 0 on any other outcome. rsp_addr is 0 on any outcome other than 2.
- R11: All storage resets to 0. A write whose outcome is 2, 3 or 4 updates only its target and returns rsp_rdata = 0. A read of those outcomes returns the stored value. Outcomes 0 and 1 modify nothing and return rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_level | input | 2 | Current privilege level |
| req_op0 | input | 2 | Selector field op0 |
| req_op1 | input | 3 | Selector field op1 |
| req_crn | input | 4 | Selector field CRn |
| req_crm | input | 4 | Selector field CRm |
| req_op2 | input | 3 | Selector field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| hv_enable | input | 1 | Hypervisor enabled in the current security state |
| nest_base | input | 1 | Base nested-virtualization bit |
| nest_el1 | input | 1 | Nested bit for level-1 register redirection |
| nest_mem | input | 1 | Nested bit for memory redirection |
| host_mode | input | 1 | Host-extension mode |
| vm_trap_rd | input | 1 | Virtual-memory read trap |
| vm_trap_wr | input | 1 | Virtual-memory write trap |
| fg_trap_rd | input | 1 | Fine-grained read trap |
| fg_trap_wr | input | 1 | Fine-grained write trap |
| fg_enable | input | 1 | Fine-grained trap enable |
| top_level_present | input | 1 | Highest privilege level implemented |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 3 | Outcome code 0..4 |
| rsp_syndrome | output | SYN_W | Trap syndrome |
| rsp_addr | output | ADDR_W | Memory slot offset on redirect |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The memory-redirect slot is the hardest state to reach and to observe. It is only reachable when all of the following hold:

- the request is at level 1 and uses the kernel encoding;
- the hypervisor is enabled;
- all three nest bits are set;
- both trap layers are quiet for the request's direction.

Its contents can only be read back through that same path. The stimulus writes a value under exactly those conditions. It then sets a virtual-memory trap, so that the trap rule must pre-empt the redirect. Finally it clears the trap and reads the slot back, which shows that the trapped write never reached storage.

// File: rtl/sysreg_dec_pkg.sv
package sysreg_dec_pkg;

   typedef enum logic [2:0] {
      OUT_UNDEF = 3'd0,
      OUT_TRAP  = 3'd1,
      OUT_MEM   = 3'd2,
      OUT_KREG  = 3'd3,
      OUT_HREG  = 3'd4
   } outcome_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_KERN = 2'd1,
      SEL_HYP  = 2'd2
   } sel_e;

   typedef struct packed {
      logic [1:0] op0;
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
   } sel_code_t;

   typedef struct packed {
      logic hv_en;
      logic nest_base;
      logic nest_el1;
      logic nest_mem;
      logic host;
      logic vm_rd;
      logic vm_wr;
      logic fg_rd;
      logic fg_wr;
      logic fg_en;
      logic top_present;
   } ctl_t;

   localparam logic [1:0] ENC_OP0      = 2'b11;
   localparam logic [2:0] ENC_OP1_KERN = 3'b000;
   localparam logic [2:0] ENC_OP1_HYP  = 3'b100;
   localparam logic [3:0] ENC_CRN      = 4'b0110;
   localparam logic [3:0] ENC_CRM      = 4'b0000;
   localparam logic [2:0] ENC_OP2      = 3'b000;

   // storage indices
   localparam int unsigned IDX_KREG = 0;
   localparam int unsigned IDX_HREG = 1;
   localparam int unsigned IDX_SLOT = 2;
   localparam int unsigned NUM_STORE = 3;

endpackage

// File: rtl/sysreg_sel_match.sv
module sysreg_sel_match
   import sysreg_dec_pkg::*;
(
   input  sel_code_t code,
   output sel_e      which
);
   logic common_ok;

   always_comb begin
      common_ok = (code.op0 == ENC_OP0) && (code.crn == ENC_CRN) &&
                  (code.crm == ENC_CRM) && (code.op2 == ENC_OP2);
      which = SEL_NONE;
      if (common_ok && code.op1 == ENC_OP1_KERN) which = SEL_KERN;
      else if (common_ok && code.op1 == ENC_OP1_HYP) which = SEL_HYP;
   end
endmodule

// File: rtl/sysreg_route_policy.sv
module sysreg_route_policy
   import sysreg_dec_pkg::*;
(
   input  logic [1:0] level,
   input  sel_e       which,
   input  logic       is_write,
   input  ctl_t       ctl,
   output outcome_e   outcome
);
   logic vm_hit;
   logic fg_hit;
   logic fg_live;

   always_comb begin
      vm_hit  = is_write ? ctl.vm_wr : ctl.vm_rd;
      fg_live = ctl.fg_en || !ctl.top_present;
      fg_hit  = fg_live && (is_write ? ctl.fg_wr : ctl.fg_rd);
      outcome = OUT_UNDEF;
      if (which != SEL_NONE) begin
         unique case (level)
            2'd0: outcome = OUT_UNDEF;
            2'd1: begin
               if (which == SEL_HYP) begin
                  if (ctl.hv_en && ctl.nest_mem && ctl.nest_base) outcome = OUT_KREG;
                  else if (ctl.hv_en && ctl.nest_base)            outcome = OUT_TRAP;
                  else                                            outcome = OUT_UNDEF;
               end else begin
                  if (ctl.hv_en && vm_hit)      outcome = OUT_TRAP;
                  else if (ctl.hv_en && fg_hit) outcome = OUT_TRAP;
                  else if (ctl.hv_en && ctl.nest_mem && ctl.nest_el1 && ctl.nest_base)
                                                outcome = OUT_MEM;
                  else                          outcome = OUT_KREG;
               end
            end
            2'd2: outcome = (which == SEL_HYP || ctl.host) ? OUT_HREG : OUT_KREG;
            default: outcome = (which == SEL_HYP) ? OUT_HREG : OUT_KREG;
         endcase
      end
   end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store #(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned NUM_ENTRIES = 3,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [DATA_W-1:0]             rd_data,
   output logic [NUM_ENTRIES*DATA_W-1:0] state_flat
);
   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                       q <= RESET_VAL;
         else if (wr_en && wr_idx == IDX_W'(g))            q <= wr_data;
      end
      assign state_flat[g*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_ENTRIES; i++)
         if (rd_idx == IDX_W'(i)) rd_data = state_flat[i*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/sysreg_access_dec.sv
module sysreg_access_dec
   import sysreg_dec_pkg::*;
#(
   parameter int unsigned DATA_W        = 64,
   parameter int unsigned SYN_W         = 6,
   parameter int unsigned ADDR_W        = 12,
   parameter logic [SYN_W-1:0]  TRAP_SYN    = 6'h18,
   parameter logic [ADDR_W-1:0] SLOT_OFFSET = 12'h220,
   parameter logic [DATA_W-1:0] RESET_VAL   = '0,
   localparam int unsigned IDX_W = $clog2(NUM_STORE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_level,
   input  logic [1:0]        req_op0,
   input  logic [2:0]        req_op1,
   input  logic [3:0]        req_crn,
   input  logic [3:0]        req_crm,
   input  logic [2:0]        req_op2,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              hv_enable,
   input  logic              nest_base,
   input  logic              nest_el1,
   input  logic              nest_mem,
   input  logic              host_mode,
   input  logic              vm_trap_rd,
   input  logic              vm_trap_wr,
   input  logic              fg_trap_rd,
   input  logic              fg_trap_wr,
   input  logic              fg_enable,
   input  logic              top_level_present,
   output logic              rsp_valid,
   output logic [2:0]        rsp_outcome,
   output logic [SYN_W-1:0]  rsp_syndrome,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [DATA_W-1:0] rsp_rdata
);
   if (DATA_W < 32) begin : g_bad_width
      $error("DATA_W must be at least 32");
   end
   if (SYN_W < 5) begin : g_bad_syn
      $error("SYN_W too narrow for the trap syndrome");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W too narrow for the slot offset");
   end

   sel_code_t code;
   ctl_t      ctl;
   sel_e      which;
   outcome_e  dec;
   logic      hit;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] rd_data;
   logic [NUM_STORE*DATA_W-1:0] store_flat;

   assign code = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
   assign ctl  = '{hv_en: hv_enable, nest_base: nest_base, nest_el1: nest_el1,
                   nest_mem: nest_mem, host: host_mode, vm_rd: vm_trap_rd,
                   vm_wr: vm_trap_wr, fg_rd: fg_trap_rd, fg_wr: fg_trap_wr,
                   fg_en: fg_enable, top_present: top_level_present};

   sysreg_sel_match u_match (.code(code), .which(which));

   sysreg_route_policy u_policy (
      .level(req_level), .which(which), .is_write(req_write),
      .ctl(ctl), .outcome(dec)
   );

   always_comb begin
      hit = 1'b1;
      unique case (dec)
         OUT_KREG: idx = IDX_W'(IDX_KREG);
         OUT_HREG: idx = IDX_W'(IDX_HREG);
         OUT_MEM:  idx = IDX_W'(IDX_SLOT);
         default: begin
            idx = '0;
            hit = 1'b0;
         end
      endcase
   end

   sysreg_store #(.DATA_W(DATA_W), .NUM_ENTRIES(NUM_STORE), .RESET_VAL(RESET_VAL)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(req_valid && req_write && hit), .wr_idx(idx), .wr_data(req_wdata),
      .rd_idx(idx), .rd_data(rd_data), .state_flat(store_flat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_outcome  <= 3'd0;
         rsp_syndrome <= '0;
         rsp_addr     <= '0;
         rsp_rdata    <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_outcome  <= dec;
            rsp_syndrome <= (dec == OUT_TRAP) ? TRAP_SYN : '0;
            rsp_addr     <= (dec == OUT_MEM) ? SLOT_OFFSET : '0;
            rsp_rdata    <= (hit && !req_write) ? rd_data : '0;
         end
      end
   end
endmodule

// File: rtl/sysreg_access_dec_chk.sv
module sysreg_access_dec_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SYN_W  = 6,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NUM_ST = 3,
   parameter logic [SYN_W-1:0]  TRAP_SYN    = 6'h18,
   parameter logic [ADDR_W-1:0] SLOT_OFFSET = 12'h220
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic [1:0]               req_level,
   input logic                     rsp_valid,
   input logic [2:0]               rsp_outcome,
   input logic [SYN_W-1:0]         rsp_syndrome,
   input logic [ADDR_W-1:0]        rsp_addr,
   input logic [NUM_ST*DATA_W-1:0] store_flat
);
   // R10
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R10
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R10
   trap_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_outcome == 3'd1) |-> rsp_syndrome == TRAP_SYN);
   // R10
   quiet_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_outcome != 3'd1) |-> rsp_syndrome == '0);
   // R10
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_outcome <= 3'd4);
   // R2
   lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_level == 2'd0) |=> rsp_outcome == 3'd0);
   // R9
   lvl3_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_level == 2'd3) |=> (rsp_outcome == 3'd0 || rsp_outcome >= 3'd3));
   // R6
   slot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_outcome == 3'd2) |-> rsp_addr == SLOT_OFFSET);
   // R11
   no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_outcome <= 3'd1) |-> $stable(store_flat));
endmodule

bind sysreg_access_dec sysreg_access_dec_chk #(
   .DATA_W(DATA_W), .SYN_W(SYN_W), .ADDR_W(ADDR_W), .NUM_ST(3),
   .TRAP_SYN(TRAP_SYN), .SLOT_OFFSET(SLOT_OFFSET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
   .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_syndrome(rsp_syndrome),
   .rsp_addr(rsp_addr), .store_flat(store_flat)
);

// File: tb/sysreg_access_dec_tb.sv
module sysreg_access_dec_tb;
   localparam int DW = 64;

   typedef struct packed {
      logic [2:0]    oc;
      logic [5:0]    syn;
      logic [11:0]   addr;
      logic [DW-1:0] rd;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_level = '0;
   logic [1:0] req_op0 = '0;
   logic [2:0] req_op1 = '0;
   logic [3:0] req_crn = '0;
   logic [3:0] req_crm = '0;
   logic [2:0] req_op2 = '0;
   logic req_write = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic hv_enable = 0, nest_base = 0, nest_el1 = 0, nest_mem = 0, host_mode = 0;
   logic vm_trap_rd = 0, vm_trap_wr = 0, fg_trap_rd = 0, fg_trap_wr = 0;
   logic fg_enable = 0, top_level_present = 1;
   logic rsp_valid;
   logic [2:0] rsp_outcome;
   logic [5:0] rsp_syndrome;
   logic [11:0] rsp_addr;
   logic [DW-1:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t  exp_q[$];
   string tag_q[$];
   logic [DW-1:0] sh_k = '0, sh_h = '0, sh_m = '0;

   sysreg_access_dec u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
      .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
      .req_op2(req_op2), .req_write(req_write), .req_wdata(req_wdata),
      .hv_enable(hv_enable), .nest_base(nest_base), .nest_el1(nest_el1),
      .nest_mem(nest_mem), .host_mode(host_mode), .vm_trap_rd(vm_trap_rd),
      .vm_trap_wr(vm_trap_wr), .fg_trap_rd(fg_trap_rd), .fg_trap_wr(fg_trap_wr),
      .fg_enable(fg_enable), .top_level_present(top_level_present),
      .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_syndrome(rsp_syndrome),
      .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata)
   );

   always #10 clk = ~clk;

   // expected outcome from the requirements (R2..R9); hyp=1 selects op1=3'b100
   function automatic logic [2:0] model(input logic [1:0] lvl, input bit hyp,
                                        input bit bad, input bit wr);
      bit vm, fg;
      if (bad) return 3'd0;
      vm = wr ? vm_trap_wr : vm_trap_rd;
      fg = (fg_enable || !top_level_present) && (wr ? fg_trap_wr : fg_trap_rd);
      case (lvl)
         2'd0: return 3'd0;
         2'd1:
            if (hyp) begin
               if (hv_enable && nest_mem && nest_base) return 3'd3;
               if (hv_enable && nest_base) return 3'd1;
               return 3'd0;
            end else begin
               if (hv_enable && vm) return 3'd1;
               if (hv_enable && fg) return 3'd1;
               if (hv_enable && nest_mem && nest_el1 && nest_base) return 3'd2;
               return 3'd3;
            end
         2'd2: return (hyp || host_mode) ? 3'd4 : 3'd3;
         default: return hyp ? 3'd4 : 3'd3;
      endcase
   endfunction

   task automatic issue(input logic [1:0] lvl, input bit hyp, input bit bad,
                        input bit wr, input logic [DW-1:0] wd, input string tag);
      exp_t e;
      logic [2:0] oc;
      @(posedge clk); #2;
      req_valid = 1'b1; req_level = lvl; req_op0 = 2'b11;
      req_op1 = hyp ? 3'b100 : 3'b000;
      req_crn = bad ? 4'b0111 : 4'b0110; req_crm = 4'b0000; req_op2 = 3'b000;
      req_write = wr; req_wdata = wd;
      oc = model(lvl, hyp, bad, wr);
      e.oc = oc;
      e.syn = (oc == 3'd1) ? 6'h18 : 6'h00;
      e.addr = (oc == 3'd2) ? 12'h220 : 12'h000;
      e.rd = '0;
      if (!wr) begin
         if (oc == 3'd3) e.rd = sh_k;
         if (oc == 3'd4) e.rd = sh_h;
         if (oc == 3'd2) e.rd = sh_m;
      end else begin
         if (oc == 3'd3) sh_k = wd;
         if (oc == 3'd4) sh_h = wd;
         if (oc == 3'd2) sh_m = wd;
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic clear_ctl();
      hv_enable = 0; nest_base = 0; nest_el1 = 0; nest_mem = 0; host_mode = 0;
      vm_trap_rd = 0; vm_trap_wr = 0; fg_trap_rd = 0; fg_trap_wr = 0;
      fg_enable = 0; top_level_present = 1;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected response outcome=%0d expected none (R10)", rsp_outcome);
         end else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rsp_outcome !== e.oc || rsp_syndrome !== e.syn ||
                rsp_addr !== e.addr || rsp_rdata !== e.rd) begin
               errors++;
               $display("FAIL %s: got oc=%0d syn=%h addr=%h rd=%h expected oc=%0d syn=%h addr=%h rd=%h",
                        t, rsp_outcome, rsp_syndrome, rsp_addr, rsp_rdata,
                        e.oc, e.syn, e.addr, e.rd);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired (R10)");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_rdata !== '0) begin
         errors++;
         $display("FAIL R11 reset: got valid=%b rd=%h expected valid=0 rd=0", rsp_valid, rsp_rdata);
      end
      rst_n = 1'b1;

      // R9 / R11: reset contents and direct mapping at level 3
      issue(2'd3, 0, 0, 0, '0, "R9 R11 L3 kernel read after reset");
      issue(2'd3, 1, 0, 0, '0, "R9 R11 L3 hyp read after reset");
      issue(2'd3, 0, 0, 1, 64'hAAAA_0000_1111_2222, "R9 L3 kernel write");
      issue(2'd3, 1, 0, 1, 64'hBBBB_3333_4444_5555, "R9 L3 hyp write");
      issue(2'd3, 0, 0, 0, '0, "R9 L3 kernel readback");
      issue(2'd3, 1, 0, 0, '0, "R9 L3 hyp readback");

      // R2: level 0 undefined, nothing written
      hv_enable = 1; nest_base = 1; nest_mem = 1;
      issue(2'd0, 0, 0, 1, 64'hDEAD, "R2 L0 kernel write");
      issue(2'd0, 1, 0, 1, 64'hBEEF, "R2 L0 hyp write");
      clear_ctl();
      issue(2'd3, 0, 0, 0, '0, "R2 R11 kernel unchanged");
      issue(2'd3, 1, 0, 0, '0, "R2 R11 hyp unchanged");

      // R1: bad selector
      issue(2'd3, 0, 1, 1, 64'h1234, "R1 bad selector write");
      issue(2'd3, 0, 1, 0, '0, "R1 bad selector read");
      issue(2'd3, 0, 0, 0, '0, "R1 kernel unchanged");

      // R3: level-1 hypervisor encoding
      hv_enable = 0; nest_base = 1; nest_mem = 1;
      issue(2'd1, 1, 0, 0, '0, "R3 hv off undefined");
      hv_enable = 1; nest_mem = 0;
      issue(2'd1, 1, 0, 1, 64'h77, "R3 nest_base trap");
      nest_mem = 1;
      issue(2'd1, 1, 0, 1, 64'h0000_0000_CAFE_0001, "R3 aliased to kernel write");
      issue(2'd1, 1, 0, 0, '0, "R3 aliased to kernel read");
      nest_base = 0;
      issue(2'd1, 1, 0, 0, '0, "R3 no nest undefined");
      clear_ctl();
      issue(2'd3, 1, 0, 0, '0, "R3 R11 hyp untouched");

      // R4: virtual-memory traps by direction
      hv_enable = 1; vm_trap_rd = 1;
      issue(2'd1, 0, 0, 0, '0, "R4 vm read trap");
      issue(2'd1, 0, 0, 1, 64'h4444, "R4 write passes with read trap");
      vm_trap_rd = 0; vm_trap_wr = 1;
      issue(2'd1, 0, 0, 1, 64'h5555, "R4 vm write trap");
      issue(2'd1, 0, 0, 0, '0, "R4 R11 read passes, trapped write absent");

      // R7: hypervisor disabled ignores all trap and nest bits
      hv_enable = 0; vm_trap_rd = 1; fg_trap_rd = 1; fg_enable = 1;
      nest_base = 1; nest_el1 = 1; nest_mem = 1;
      issue(2'd1, 0, 0, 0, '0, "R7 hv off kernel read");
      clear_ctl(); hv_enable = 1;
      issue(2'd1, 0, 0, 0, '0, "R7 plain kernel read");

      // R5: fine-grained trap and its qualifier
      fg_trap_rd = 1; fg_enable = 0; top_level_present = 1;
      issue(2'd1, 0, 0, 0, '0, "R5 fg inactive");
      top_level_present = 0;
      issue(2'd1, 0, 0, 0, '0, "R5 fg with top level absent");
      top_level_present = 1; fg_enable = 1;
      issue(2'd1, 0, 0, 0, '0, "R5 fg enabled read trap");
      issue(2'd1, 0, 0, 1, 64'h6666, "R5 write ignores read fg bit");
      fg_trap_rd = 0; fg_trap_wr = 1;
      issue(2'd1, 0, 0, 1, 64'h7777, "R5 fg write trap");
      clear_ctl();

      // R6: memory redirect and trap priority above it
      hv_enable = 1; nest_base = 1; nest_el1 = 1; nest_mem = 1;
      issue(2'd1, 0, 0, 0, '0, "R6 slot read after reset");
      issue(2'd1, 0, 0, 1, 64'h0123_4567_89AB_CDEF, "R6 slot write");
      vm_trap_wr = 1;
      issue(2'd1, 0, 0, 1, 64'hFFFF, "R4 R6 vm trap beats redirect");
      vm_trap_wr = 0;
      issue(2'd1, 0, 0, 0, '0, "R6 slot readback");
      nest_el1 = 0;
      issue(2'd1, 0, 0, 0, '0, "R6 R7 missing nest bit goes to kernel");
      clear_ctl();

      // R8: level 2 aliasing
      host_mode = 0;
      issue(2'd2, 0, 0, 0, '0, "R8 L2 kernel no host");
      host_mode = 1;
      issue(2'd2, 0, 0, 1, 64'h8888_0000, "R8 L2 kernel enc to hyp write");
      issue(2'd2, 1, 0, 0, '0, "R8 L2 hyp enc read");
      host_mode = 0;
      issue(2'd2, 1, 0, 0, '0, "R8 L2 hyp enc without host");
      issue(2'd3, 0, 0, 0, '0, "R8 kernel untouched");

      repeat (4) @(posedge clk);
      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R10 missing responses: got %0d pending expected 0", exp_q.size());
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule